// File: doc/BRIEF.md
# I2C Controller Control Register with Write Lock

This block holds the main configuration word of an I2C controller as a 32-bit memory-mapped register. A single-cycle write port updates it, and a combinational read port returns it. A write takes effect only while the controller's separate enable flag is clear. A write made while the controller runs is dropped without any trace.

The stored fields are the master enable, a two-bit speed code, slave 10-bit addressing, restart permission, slave disable, stop reporting limited to addressed transfers, and transmit-empty control. Each field is decoded onto its own output pin. The master-side 10-bit addressing flag is fixed at 1 and cannot be written. The upper reserved bits always read 0. A speed code outside the legal set is replaced by the fast-mode code before it is stored. A configuration error output flags the master-on / slave-on combination without changing the stored bits.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the readback word is 0x0000007D. That is: bit0 master enable = 1, bits 2:1 speed = 2, bit3 slave 10-bit = 1, bit4 = 1, bit5 restart enable = 1, bit6 slave disable = 1, bit7 addressed-only stop = 0, bit8 transmit-empty control = 0.
- R2: A write while `ctl_enable` is 1 leaves every stored field and output unchanged.
- R3: A write to the register offset with `ctl_enable` = 0 updates bits 0, 3, 5, 6, 7, 8 and the speed field at the next clock edge. Readback then shows the new value.
- R4: Bit 4 of the readback always reads 1, whatever is written, and the `mst_addr10` output is always 1.
- R5: Readback bits 31:9 always read 0, whatever is written.
- R6: The speed field (bits 2:1) stores a written 1 or 2 as is. It stores a written 0 or 3 as 2. It is stored whatever the master enable value.
- R7: `cfg_err` is 1 exactly when the stored master enable is 1 and the stored slave disable is 0. The stored bits are not altered.
- R8: A write to any address other than `REG_OFF` changes nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable flag; 1 locks the register |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| master_en | output | 1 | Master enable |
| speed_sel | output | 2 | Speed code (1 standard, 2 fast) |
| slv_addr10 | output | 1 | Slave responds to 10-bit addresses |
| mst_addr10 | output | 1 | Master 10-bit addressing (fixed 1) |
| restart_en | output | 1 | Restart conditions permitted |
| slave_off | output | 1 | Slave function disabled |
| stop_addr_only | output | 1 | Stop reported only when addressed |
| txe_ctrl | output | 1 | Transmit-empty control |
| cfg_err | output | 1 | Master on while slave enabled |

## Verification
A corrupted stored field shows on its decoded output pin and in the readback word in the cycle right after the clock edge that corrupted it. A write that slips past the lock, or lands from a wrong address, shows at the next edge. An illegal speed code would appear directly on `speed_sel`. The bench compares the full readback word and every output against a behavioural model on each cycle, so any such defect is caught within one clock.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int FIELD_BITS = 9;

    localparam logic [1:0] SPD_STD  = 2'd1;
    localparam logic [1:0] SPD_FAST = 2'd2;

    typedef struct packed {
        logic       txe_ctrl;
        logic       stop_addr_only;
        logic       slave_off;
        logic       restart_en;
        logic       slv_addr10;
        logic [1:0] speed;
        logic       master_en;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{
        txe_ctrl:       1'b0,
        stop_addr_only: 1'b0,
        slave_off:      1'b1,
        restart_en:     1'b1,
        slv_addr10:     1'b1,
        speed:          SPD_FAST,
        master_en:      1'b1
    };

    function automatic logic [1:0] fix_speed(input logic [1:0] code);
        return (code == SPD_STD || code == SPD_FAST) ? code : SPD_FAST;
    endfunction

    function automatic ctl_fields_t unpack_word(input logic [FIELD_BITS-1:0] w);
        ctl_fields_t f;
        f.master_en      = w[0];
        f.speed          = fix_speed(w[2:1]);
        f.slv_addr10     = w[3];
        f.restart_en     = w[5];
        f.slave_off      = w[6];
        f.stop_addr_only = w[7];
        f.txe_ctrl       = w[8];
        return f;
    endfunction

    function automatic logic [FIELD_BITS-1:0] pack_word(input ctl_fields_t f);
        return {f.txe_ctrl, f.stop_addr_only, f.slave_off, f.restart_en,
                1'b1, f.slv_addr10, f.speed, f.master_en};
    endfunction

endpackage

// File: rtl/i2c_ctl_wrgate.sv
module i2c_ctl_wrgate #(
    parameter int ADDR_W  = 8,
    parameter int REG_OFF = 0
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctl_enable,
    output logic              addr_hit,
    output logic              wr_accept
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFF);

    always_comb begin
        addr_hit  = (bus_addr == OFF);
        wr_accept = bus_wr && addr_hit && !ctl_enable;
    end
endmodule

// File: rtl/i2c_ctl_store.sv
module i2c_ctl_store
    import i2c_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_accept,
    input  logic                  wr_locked,
    input  logic [FIELD_BITS-1:0] wr_low,
    output ctl_fields_t           q
);
    ctl_fields_t nxt;

    always_comb nxt = unpack_word(wr_low);

    always_ff @(posedge clk) begin
        if (rst)            q <= CTL_RESET;
        else if (wr_accept) q <= nxt;
    end

    p_locked_r2: assert property (@(posedge clk) disable iff (rst)
        wr_locked |=> $stable(q));

    p_update_r3: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> (q.master_en == $past(wr_low[0]) && q.txe_ctrl == $past(wr_low[8])
                       && q.slave_off == $past(wr_low[6])));

    p_legal_speed_r6: assert property (@(posedge clk) disable iff (rst)
        (q.speed == SPD_STD || q.speed == SPD_FAST));
endmodule

// File: rtl/i2c_ctl_view.sv
module i2c_ctl_view
    import i2c_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_fields_t       q,
    input  logic              addr_hit,
    output logic [DATA_W-1:0] rdata,
    output logic              cfg_err
);
    logic [FIELD_BITS-1:0] low;

    always_comb begin
        low     = pack_word(q);
        rdata   = addr_hit ? DATA_W'(low) : '0;
        cfg_err = q.master_en && !q.slave_off;
    end

    p_fixed_bit_r4: assert property (@(posedge clk) disable iff (rst)
        addr_hit |-> rdata[4]);

    p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:FIELD_BITS] == '0);

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !addr_hit |-> rdata == '0);
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_ctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int REG_OFF = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              master_en,
    output logic [1:0]        speed_sel,
    output logic              slv_addr10,
    output logic              mst_addr10,
    output logic              restart_en,
    output logic              slave_off,
    output logic              stop_addr_only,
    output logic              txe_ctrl,
    output logic              cfg_err
);
    logic        addr_hit;
    logic        wr_accept;
    logic        wr_locked;
    ctl_fields_t q;

    i2c_ctl_wrgate #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_gate (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctl_enable(ctl_enable),
        .addr_hit  (addr_hit),
        .wr_accept (wr_accept)
    );

    always_comb wr_locked = bus_wr && ctl_enable;

    i2c_ctl_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_accept(wr_accept),
        .wr_locked(wr_locked),
        .wr_low   (bus_wdata[FIELD_BITS-1:0]),
        .q        (q)
    );

    i2c_ctl_view #(.DATA_W(DATA_W)) u_view (
        .clk     (clk),
        .rst     (rst),
        .q       (q),
        .addr_hit(addr_hit),
        .rdata   (bus_rdata),
        .cfg_err (cfg_err)
    );

    always_comb begin
        master_en      = q.master_en;
        speed_sel      = q.speed;
        slv_addr10     = q.slv_addr10;
        mst_addr10     = 1'b1;
        restart_en     = q.restart_en;
        slave_off      = q.slave_off;
        stop_addr_only = q.stop_addr_only;
        txe_ctrl       = q.txe_ctrl;
    end

    p_cfg_err_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err == (master_en && !slave_off));

    p_mst10_r4: assert property (@(posedge clk) disable iff (rst)
        mst_addr10);
endmodule

// File: tb/i2c_ctl_reg_test.sv
module i2c_ctl_reg_test;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int OFF = 8'h10;

    logic clk = 0, rst = 1, ctl_enable = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = AW'(OFF);
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic master_en, slv_addr10, mst_addr10, restart_en, slave_off;
    logic stop_addr_only, txe_ctrl, cfg_err;
    logic [1:0] speed_sel;

    int checks = 0, errors = 0;
    int model;
    bit done = 0;

    i2c_ctl_reg #(.ADDR_W(AW), .DATA_W(DW), .REG_OFF(OFF)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int sanitize(int d);
        int s, w;
        s = (d >> 1) & 3;
        if (s != 1 && s != 2) s = 2;
        w = d & 32'h1E9;
        return w | (s << 1) | 32'h10;
    endfunction

    // compare every output against the model, bus_addr assumed at OFF
    task automatic compare(string req);
        int outw;
        outw = int'(master_en) | (int'(speed_sel) << 1) | (int'(slv_addr10) << 3)
             | (int'(mst_addr10) << 4) | (int'(restart_en) << 5) | (int'(slave_off) << 6)
             | (int'(stop_addr_only) << 7) | (int'(txe_ctrl) << 8);
        chk(req, int'(bus_rdata), model);
        chk(req, outw, model);
        chk("R7", int'(cfg_err), int'((model & 1) == 1 && (model & 64) == 0));
    endtask

    // one bus cycle: drive at negedge, model updates at posedge, compare next negedge
    task automatic cycle(bit wr, bit en, int addr, int data, string req);
        bus_wr = wr; ctl_enable = en; bus_addr = AW'(addr); bus_wdata = DW'(data);
        @(posedge clk);
        if (wr && !en && addr == OFF) model = sanitize(data);
        @(negedge clk);
        bus_wr = 0; bus_addr = AW'(OFF);
        #1 compare(req);
    endtask

    initial begin
        model = 32'h7D;
        repeat (3) @(negedge clk);
        rst = 0;
        #1 compare("R1");

        cycle(1, 0, OFF, 32'h0000_01A3, "R3");
        cycle(1, 0, OFF, 32'h0000_0040, "R3");
        cycle(1, 1, OFF, 32'h0000_0183, "R2");
        cycle(1, 1, OFF, 32'hFFFF_FFFF, "R2");
        cycle(1, 0, OFF, 32'hFFFF_FFEF, "R5");
        chk("R5", int'(bus_rdata[31:9]), 0);
        chk("R4", int'(bus_rdata[4]), 1);
        cycle(1, 0, OFF, 32'h0000_0000, "R4");
        chk("R4", int'(bus_rdata[4]), 1);
        chk("R6", int'(speed_sel), 2);
        cycle(1, 0, OFF, 32'h0000_0002, "R6");
        chk("R6", int'(speed_sel), 1);
        cycle(1, 0, OFF, 32'h0000_0006, "R6");
        chk("R6", int'(speed_sel), 2);
        cycle(1, 0, OFF, 32'h0000_0002, "R6");
        cycle(1, 0, OFF, 32'h0000_0004, "R6");
        chk("R6", int'(speed_sel), 2);
        cycle(1, 0, OFF, 32'h0000_0001, "R7");
        chk("R7", int'(cfg_err), 1);
        chk("R7", int'(master_en), 1);
        cycle(1, 0, OFF, 32'h0000_0041, "R7");
        chk("R7", int'(cfg_err), 0);
        cycle(1, 0, OFF + 4, 32'h0000_0000, "R8");
        cycle(1, 0, 0, 32'h0000_0180, "R8");
        bus_addr = AW'(OFF + 1);
        #1 chk("R8", int'(bus_rdata), 0);
        bus_addr = AW'(OFF);
        for (int i = 0; i < 300; i++) begin
            int a;
            a = ($urandom % 4 == 0) ? ($urandom % 256) : OFF;
            cycle($urandom % 2 == 1, $urandom % 3 == 0, a, int'($urandom), "R3");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule